// File: doc/BRIEF.md
# Frame-Triplet Capture Status Controller

This block sits between a camera link and a host DMA engine. Image frames arrive in fixed groups of three, called triplets. The block tracks which frames of the stored triplets are still waiting for the host. It tells the host, through one status word, which position (1, 2 or 3) of the oldest waiting triplet should be moved next. It also reports DMA completions and cable-status changes, and raises one interrupt line. Pixel storage, the bus protocol and the DMA datapath are outside the block: it sees only a strobe per frame slot, a cable-present level, a DMA-done pulse and a small register port.

The block holds up to `NBUF` triplets. If a new triplet starts while every triplet buffer is still occupied, the block throws that whole triplet away and does not overwrite stored data. It counts each discarded triplet in a saturating counter, which the host clears by reading the status word. Clearing the capture-enable bit, or pulling the cable, throws away all buffered sequencing, so capture always restarts at frame 1 of a triplet.

Register map (word addresses on `reg_addr`): 0 = frame size in 4096-byte pages (read-only), 1 = control, 2 = status, 3 = cable level (read-only). A read returns its data on `reg_rdata` one clock after `reg_rd`.

Top module: `triplet_capture_ctrl`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), the control register, the status word, `reg_rdata` and `irq` are all zero.
- R2: Address 0 reads the `FRAME_PAGES` parameter. Address 3 reads the cable level in bit 0. Writes to addresses 0 and 3 change nothing.
- R3: Status bits 1:0 give the 1-based position (1..3) of the oldest frame not yet transferred. The value 0 means no frame is waiting.
- R4: A `dma_done` pulse while a frame is waiting retires that frame and sets status bit 2. The bit stays set until a status write with bit 2 set clears it. A `dma_done` with nothing waiting changes nothing.
- R5: Frames are taken only in the order slot 1, 2, 3, where `frame_strobe[k]` marks slot k+1. A strobe on any other slot is ignored.
- R6: A triplet that starts while all `NBUF` triplet buffers are occupied is discarded whole, and status bits 15:8 are incremented. The triplets already stored are kept.
- R7: The discarded-triplet count saturates at 255. A status read returns the count and clears it in the same cycle.
- R8: Control bit 0 enables capture. While it is 0, all buffered frames are discarded and strobes are ignored. After it is set again, capture resumes at slot 1.
- R9: Any change of `cable_in` sets status bit 3, which is cleared by a status write with bit 3 set. While the cable is absent, sequencing is reset and strobes are ignored.
- R10: `irq` equals (control bit 0 AND (status bits 1:0 nonzero OR status bit 2)) OR (control bit 1 AND status bit 3). So a status read of zero means this block did not raise the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_strobe | input | 3 | One-cycle pulse per frame slot; bit k marks slot k+1 |
| cable_in | input | 1 | Cable present level (1 = present) |
| dma_done | input | 1 | One-cycle pulse when the host finishes a frame transfer |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Interrupt request |

## Verification
The in-RTL assertions check, on every cycle, several invariants. Triplet occupancy and the waiting-frame count never exceed capacity. The arrival and transfer positions move only on a strobe, a completion or a flush. The dropped count never falls except on a status read, and rises only when the buffers were full. The completion flag is sticky. A cable edge always sets the cable flag. The interrupt never rises while the status word is zero. Only the bench's scenarios can show the exact status values seen by the host:
- the wrap from position 3 back to 1;
- that a discarded triplet leaves the stored ones intact;
- saturation at 255 and clear-on-read;
- restart at slot 1 after a disable or an unplug;
- that out-of-order strobes and surplus completions have no effect.

// File: rtl/tcc_pkg.sv
// Shared constants for the triplet capture controller.
// Assumes a fixed triplet length of three frames and an 8-bit drop count.
package tcc_pkg;
    localparam int TRIP_LEN = 3;
    localparam int DROP_W   = 8;
    localparam int RD_W     = 32;

    typedef logic [1:0] pos_t;

    // Register word addresses
    localparam logic [1:0] A_SIZE   = 2'd0;
    localparam logic [1:0] A_CTRL   = 2'd1;
    localparam logic [1:0] A_STATUS = 2'd2;
    localparam logic [1:0] A_CABLE  = 2'd3;

    // Status bit positions (the host decodes these)
    localparam int S_DONE  = 2;
    localparam int S_CABLE = 3;
    localparam int S_DROP  = 8;

    localparam pos_t POS_LAST = pos_t'(TRIP_LEN - 1);
endpackage

// File: rtl/tcc_store.sv
// Occupancy bookkeeping for the triplet buffers.
// Counts triplets that have been opened and are not fully transferred,
// and frames that are stored but not yet handed to the host.
// Assumes start and accept never both fire without a matching frame.
module tcc_store #(
    parameter int NBUF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic start,
    input  logic accept,
    input  logic sent,
    input  logic last,
    output logic occ_full,
    output logic avail_nz
);
    localparam int OCC_W = $clog2(NBUF + 1);
    localparam int AV_W  = $clog2(tcc_pkg::TRIP_LEN * NBUF + 1);

    logic [OCC_W-1:0] occ;
    logic [AV_W-1:0]  avail;
    logic             past_ok;

    // Triplet occupancy: +1 on a kept triplet start, -1 when its last frame leaves
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            occ <= '0;
        end else begin
            case ({start, last})
                2'b10:   occ <= occ + OCC_W'(1);
                2'b01:   occ <= occ - OCC_W'(1);
                default: occ <= occ;
            endcase
        end
    end

    // Waiting-frame count: +1 per stored frame, -1 per transferred frame
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            avail <= '0;
        end else begin
            case ({accept, sent})
                2'b10:   avail <= avail + AV_W'(1);
                2'b01:   avail <= avail - AV_W'(1);
                default: avail <= avail;
            endcase
        end
    end

    // Marks cycles where $past refers to post-reset state
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assign occ_full = (occ == OCC_W'(NBUF));
    assign avail_nz = (avail != '0);

    // R6
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> occ <= OCC_W'(NBUF));

    // R3
    avail_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> avail <= AV_W'(tcc_pkg::TRIP_LEN * NBUF));
endmodule

// File: rtl/tcc_ingest.sv
// Arrival sequencer: takes frame strobes strictly in slot order 1,2,3,
// opens a triplet only when a buffer is free, otherwise discards the
// whole triplet and counts it in a saturating drop counter.
// Assumes frame_strobe bits are single-cycle pulses.
module tcc_ingest
    import tcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [2:0]        frame_strobe,
    input  logic              occ_full,
    input  logic              cnt_clr,
    output logic              start,
    output logic              accept,
    output logic [DROP_W-1:0] drop_cnt
);
    localparam logic [DROP_W-1:0] CNT_MAX = {DROP_W{1'b1}};

    pos_t       arr_pos;
    logic       dropping;
    logic [3:0] fs_pad;
    logic       slot_hit;
    logic       trip_open;
    logic       drop_now;
    logic       past_ok;

    assign fs_pad = {1'b0, frame_strobe};

    // Decode the strobe that matches the expected slot and the buffer decision
    always_comb begin
        slot_hit  = ~flush & fs_pad[arr_pos];
        trip_open = slot_hit & (arr_pos == '0);
        drop_now  = trip_open & occ_full;
        start     = trip_open & ~occ_full;
        accept    = start | (slot_hit & (arr_pos != '0) & ~dropping);
    end

    // Expected slot position and discard mode for the triplet in flight
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            arr_pos  <= '0;
            dropping <= 1'b0;
        end else if (slot_hit) begin
            arr_pos <= (arr_pos == POS_LAST) ? '0 : arr_pos + pos_t'(1);
            if (trip_open) dropping <= drop_now;
        end
    end

    // Saturating discarded-triplet counter, cleared by a status read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_cnt <= '0;
        end else if (cnt_clr) begin
            drop_cnt <= drop_now ? DROP_W'(1) : '0;
        end else if (drop_now && drop_cnt != CNT_MAX) begin
            drop_cnt <= drop_cnt + DROP_W'(1);
        end
    end

    // Marks cycles where $past refers to post-reset state
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R7
    drop_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(cnt_clr) |-> drop_cnt >= $past(drop_cnt));

    // R6
    drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(cnt_clr) && (drop_cnt != $past(drop_cnt)) |-> $past(occ_full));

    // R5
    arr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(flush) && ($past(frame_strobe) == 3'b000) |-> $stable(arr_pos));
endmodule

// File: rtl/tcc_drain.sv
// Transfer-side sequencer: presents the 1-based position of the oldest
// waiting frame and retires it on each DMA completion.
// Assumes the host transfers frames of a triplet in slot order.
module tcc_drain
    import tcc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic dma_done,
    input  logic avail_nz,
    output logic sent,
    output logic last,
    output pos_t next_idx
);
    pos_t tx_pos;
    logic past_ok;

    // Completion qualifies only when a frame is actually waiting
    always_comb begin
        sent     = dma_done & avail_nz & ~flush;
        last     = sent & (tx_pos == POS_LAST);
        next_idx = (avail_nz & ~flush) ? tx_pos + pos_t'(1) : '0;
    end

    // Position within the head triplet of the next frame to move
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            tx_pos <= '0;
        end else if (sent) begin
            tx_pos <= (tx_pos == POS_LAST) ? '0 : tx_pos + pos_t'(1);
        end
    end

    // Marks cycles where $past refers to post-reset state
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R4
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$past(flush) && !$past(dma_done) |-> $stable(tx_pos));
endmodule

// File: rtl/tcc_regs.sv
// Register port, sticky event flags, cable edge detection and interrupt.
// Read data is registered and valid one cycle after reg_rd; a status read
// clears the drop counter at the same edge. Assumes cable_in is already
// synchronous to clk.
module tcc_regs
    import tcc_pkg::*;
#(
    parameter int FRAME_PAGES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [RD_W-1:0]   reg_wdata,
    input  logic              cable_in,
    input  pos_t              next_idx,
    input  logic              sent,
    input  logic [DROP_W-1:0] drop_cnt,
    output logic              cap_en,
    output logic              cab_q,
    output logic              cnt_clr,
    output logic [RD_W-1:0]   reg_rdata,
    output logic              irq
);
    logic [1:0]      ctrl;
    logic            done_q;
    logic            cevt_q;
    logic [RD_W-1:0] stat;
    logic            stat_wr;
    logic            past_ok;
    logic            unused_wbits;

    assign unused_wbits = ^reg_wdata[RD_W-1:4];
    assign stat_wr      = reg_wr & (reg_addr == A_STATUS);
    assign cnt_clr      = reg_rd & (reg_addr == A_STATUS);
    assign cap_en       = ctrl[0];

    // Assemble the status word from live and sticky fields
    always_comb begin
        stat                     = '0;
        stat[1:0]                = next_idx;
        stat[S_DONE]             = done_q;
        stat[S_CABLE]            = cevt_q;
        stat[S_DROP +: DROP_W]   = drop_cnt;
    end

    // Control register: capture enable and cable-event interrupt enable
    always_ff @(posedge clk) begin
        if (!rst_n)                                 ctrl <= '0;
        else if (reg_wr && reg_addr == A_CTRL)      ctrl <= reg_wdata[1:0];
    end

    // Cable level register, loaded during reset so no false edge appears
    always_ff @(posedge clk) begin
        cab_q <= cable_in;
    end

    // Sticky completion flag: set wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= sent | (done_q & ~(stat_wr & reg_wdata[S_DONE]));
    end

    // Sticky cable-change flag on either edge of the cable level
    always_ff @(posedge clk) begin
        if (!rst_n) cevt_q <= 1'b0;
        else        cevt_q <= (cable_in != cab_q) | (cevt_q & ~(stat_wr & reg_wdata[S_CABLE]));
    end

    // Registered read mux
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            case (reg_addr)
                A_SIZE:   reg_rdata <= RD_W'(FRAME_PAGES);
                A_CTRL:   reg_rdata <= RD_W'(ctrl);
                A_STATUS: reg_rdata <= stat;
                default:  reg_rdata <= RD_W'(cab_q);
            endcase
        end
    end

    // Interrupt: OR of the enabled event sources
    assign irq = (ctrl[0] & ((next_idx != '0) | done_q)) | (ctrl[1] & cevt_q);

    // Marks cycles where $past refers to post-reset state
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R10
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> stat != '0);

    // R4
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(done_q) && !$past(stat_wr && reg_wdata[S_DONE]) |-> done_q);

    // R9
    cable_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && ($past(cable_in) != $past(cab_q)) |-> cevt_q);
endmodule

// File: rtl/triplet_capture_ctrl.sv
// Frame-triplet capture status controller, top level.
// Joins the arrival sequencer, the buffer occupancy counters, the
// transfer sequencer and the register/interrupt logic. Capture runs only
// while control bit 0 is set and the cable is present; otherwise all
// sequencing is flushed. Assumes all inputs are synchronous to clk.
module triplet_capture_ctrl
    import tcc_pkg::*;
#(
    parameter int NBUF        = 2,
    parameter int FRAME_PAGES = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      frame_strobe,
    input  logic            cable_in,
    input  logic            dma_done,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [1:0]      reg_addr,
    input  logic [RD_W-1:0] reg_wdata,
    output logic [RD_W-1:0] reg_rdata,
    output logic            irq
);
    logic              cap_en;
    logic              cab_q;
    logic              flush;
    logic              cnt_clr;
    logic              start;
    logic              accept;
    logic              sent;
    logic              last;
    logic              occ_full;
    logic              avail_nz;
    logic [DROP_W-1:0] drop_cnt;
    pos_t              next_idx;

    assign flush = ~(cap_en & cab_q);

    tcc_ingest u_ingest (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush        (flush),
        .frame_strobe (frame_strobe),
        .occ_full     (occ_full),
        .cnt_clr      (cnt_clr),
        .start        (start),
        .accept       (accept),
        .drop_cnt     (drop_cnt)
    );

    tcc_store #(.NBUF(NBUF)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .start    (start),
        .accept   (accept),
        .sent     (sent),
        .last     (last),
        .occ_full (occ_full),
        .avail_nz (avail_nz)
    );

    tcc_drain u_drain (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .dma_done (dma_done),
        .avail_nz (avail_nz),
        .sent     (sent),
        .last     (last),
        .next_idx (next_idx)
    );

    tcc_regs #(.FRAME_PAGES(FRAME_PAGES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .cable_in  (cable_in),
        .next_idx  (next_idx),
        .sent      (sent),
        .drop_cnt  (drop_cnt),
        .cap_en    (cap_en),
        .cab_q     (cab_q),
        .cnt_clr   (cnt_clr),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );
endmodule

// File: tb/sim_triplet_capture_ctrl.sv
`timescale 1ns/1ps
module sim_triplet_capture_ctrl;
    localparam int OP_WR = 1, OP_FRM = 2, OP_DONE = 3, OP_RD = 4, OP_IRQ = 5;
    localparam int NV = 63;

    function automatic logic [39:0] e(int req, int op, int arg, int exp);
        return {4'(req), 4'(op), 16'(arg), 16'(exp)};
    endfunction

    // {req, op, arg, expected}; WR arg = addr<<8 | data, FRM arg = slot
    localparam logic [39:0] VEC [0:NV-1] = '{
        e(2,OP_RD,0,16),     e(2,OP_WR,'h0FF,0), e(2,OP_RD,0,16),   e(2,OP_RD,3,1),      // R2
        e(8,OP_WR,'h101,0),  e(3,OP_RD,2,0),     e(10,OP_IRQ,0,0),                      // R8 R3 R10
        e(5,OP_FRM,1,0),     e(3,OP_RD,2,1),     e(10,OP_IRQ,0,1),                      // R5 R3
        e(5,OP_FRM,2,0),     e(5,OP_FRM,3,0),    e(4,OP_DONE,0,0),  e(4,OP_RD,2,6),     // R4
        e(4,OP_WR,'h204,0),  e(3,OP_RD,2,2),     e(4,OP_DONE,0,0),  e(4,OP_DONE,0,0),
        e(4,OP_RD,2,4),      e(4,OP_WR,'h204,0), e(4,OP_DONE,0,0),  e(4,OP_RD,2,0),     // surplus done
        e(10,OP_IRQ,0,0),    e(5,OP_FRM,3,0),    e(5,OP_FRM,2,0),   e(5,OP_RD,2,0),     // out of order
        e(6,OP_FRM,1,0),     e(6,OP_FRM,2,0),    e(6,OP_FRM,3,0),                       // R6 fill
        e(6,OP_FRM,1,0),     e(6,OP_FRM,2,0),    e(6,OP_FRM,3,0),
        e(6,OP_FRM,1,0),     e(6,OP_FRM,2,0),    e(6,OP_FRM,3,0),                       // discarded
        e(6,OP_RD,2,'h101),  e(7,OP_RD,2,1),                                            // R7 clear
        e(6,OP_DONE,0,0),    e(6,OP_DONE,0,0),   e(6,OP_DONE,0,0),
        e(6,OP_DONE,0,0),    e(6,OP_DONE,0,0),   e(6,OP_DONE,0,0),  e(6,OP_RD,2,4),
        e(4,OP_WR,'h204,0),  e(8,OP_FRM,1,0),    e(8,OP_FRM,2,0),   e(8,OP_WR,'h100,0), // R8
        e(8,OP_RD,2,0),      e(8,OP_FRM,1,0),    e(8,OP_WR,'h101,0),e(8,OP_RD,2,0),
        e(8,OP_FRM,2,0),     e(8,OP_RD,2,0),     e(8,OP_FRM,1,0),   e(8,OP_RD,2,1),
        e(8,OP_FRM,2,0),     e(8,OP_FRM,3,0),    e(8,OP_DONE,0,0),  e(8,OP_DONE,0,0),
        e(8,OP_DONE,0,0),    e(8,OP_WR,'h204,0), e(8,OP_RD,2,0)
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  frame_strobe = '0;
    logic        cable_in = 1'b1;
    logic        dma_done = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    triplet_capture_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe), .cable_in(cable_in),
        .dma_done(dma_done), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(int req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Every task starts and ends just after a falling edge
    task automatic do_wr(logic [1:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_rd(int req, logic [1:0] a, logic [31:0] exp);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        check(req, "read", reg_rdata, exp);
    endtask

    task automatic do_frm(int slot);
        frame_strobe = 3'(1 << (slot - 1));
        @(negedge clk);
        frame_strobe = '0;
    endtask

    task automatic do_done();
        dma_done = 1'b1;
        @(negedge clk);
        dma_done = 1'b0;
    endtask

    task automatic do_triplet();
        do_frm(1); do_frm(2); do_frm(3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(1, "irq after reset", 32'(irq), 0);
        check(1, "rdata after reset", reg_rdata, 0);
        do_rd(1, 2'd1, 0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            logic [3:0]  rq;
            logic [3:0]  op;
            logic [15:0] arg;
            logic [15:0] ex;
            {rq, op, arg, ex} = VEC[i];
            case (int'(op))
                OP_WR:   do_wr(arg[9:8], 32'(arg[7:0]));
                OP_FRM:  do_frm(int'(arg));
                OP_DONE: do_done();
                OP_RD:   do_rd(int'(rq), arg[1:0], 32'(ex));
                default: check(int'(rq), "irq", 32'(irq), 32'(ex));
            endcase
        end

        // R7 saturation: fill both buffers, then discard 300 triplets
        do_triplet(); do_triplet();
        for (int t = 0; t < 300; t++) do_triplet();
        do_rd(7, 2'd2, 32'hFF01);
        do_rd(7, 2'd2, 32'h0001);
        check(10, "irq with frame waiting", 32'(irq), 1);

        // R9 unplug flushes sequencing and flags the event
        cable_in = 1'b0;
        @(negedge clk); @(negedge clk);
        do_rd(9, 2'd2, 32'h0008);
        check(10, "irq cable event masked", 32'(irq), 0);
        do_frm(1);
        do_rd(9, 2'd2, 32'h0008);
        do_rd(2, 2'd3, 0);
        do_wr(2'd1, 3);
        check(10, "irq cable event enabled", 32'(irq), 1);
        do_wr(2'd2, 8);
        check(10, "irq after clear", 32'(irq), 0);
        cable_in = 1'b1;
        @(negedge clk); @(negedge clk);
        do_rd(9, 2'd2, 32'h0008);
        do_wr(2'd2, 8);
        do_frm(1);
        do_rd(9, 2'd2, 32'h0001);
        do_rd(2, 2'd3, 1);

        // R1 reset in the middle of activity
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, "irq after mid reset", 32'(irq), 0);
        do_rd(1, 2'd1, 0);
        do_rd(1, 2'd2, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule